// File: doc/BRIEF.md
# Three-Slot Uop Steering Queue

This block sits between an instruction aligner and a rename stage. Each cycle the aligner offers up to three instructions. Each one carries a uop count and a payload. The block steers them onto an asymmetric set of decode slots: one wide slot that can expand an instruction into as many as four uops, and two narrow slots that only take single-uop instructions. Every accepted instruction is expanded into uop entries. The entries are written in order into a six-entry queue, and rename drains that queue at up to three uops per cycle.

The group of instructions taken in one cycle is always a prefix of the offered slots. The group ends at the first slot that is not valid, breaks its slot rule, or does not fit in the queue. The block reports to the aligner how many instructions it took, and the aligner re-offers the rest starting at slot 0. An instruction that needs zero uops or more than four uops is never taken here, because it belongs to a separate long-flow sequencer. A flush empties the queue and cancels the group being decoded in that cycle.

Top module: `uop_steer_queue`

## Requirements
- R1: After reset the queue is empty: `out_vld_o` is 0, and `in_take_o` is 0 while no slot is valid.
- R2: An instruction taken in slot 0 with uop count n (1 to 4) yields n consecutive queue entries. Each entry carries the instruction payload and a 2-bit uop index counting 0 to n-1. The end-of-instruction bit is 1 only on the entry with index n-1.
- R3: Slots 1 and 2 take an instruction only if its uop count is exactly 1. The first slot that fails this rule ends the group, and slots after it are not taken even if they are valid single-uop instructions.
- R4: `in_take_o` equals the number of leading slots taken, from 0 to 3. A slot whose valid bit is low ends the group.
- R5: An instruction is taken only if the sum of its own uops and those of the earlier instructions in the group fits in the free space. Free space is counted as six minus the occupancy at the start of the cycle, and pops in the same cycle add no room. An instruction is never partly inserted.
- R6: The queue holds at most 6 uops and never overflows.
- R7: `out_vld_o` is a thermometer code with bit j set when the queue holds more than j uops. Lane j shows the j-th oldest uop. `out_pop_i` removes that many of the oldest uops, limited to the number present.
- R8: While `flush_i` is high, `in_take_o` is 0 and pops are ignored. After that edge the queue is empty.
- R9: Uops leave the queue in the order they were inserted, including across wrap-around of the storage.
- R10: A slot 0 instruction whose uop count is 0 or greater than 4 is never taken, and it ends the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empties the queue and cancels this cycle's decode group |
| in_vld_i | input | 3 | Valid bit per offered slot |
| in_ucnt_i | input | 9 | 3-bit uop count per slot, slot s at bits [3s+2:3s] |
| in_pay_i | input | 24 | 8-bit payload per slot, slot s at bits [8s+7:8s] |
| in_take_o | output | 2 | Number of leading slots consumed this cycle |
| out_vld_o | output | 3 | Thermometer of uops available on the output lanes |
| out_pay_o | output | 24 | Payload of output lane j at bits [8j+7:8j] |
| out_idx_o | output | 6 | Uop index within its instruction for lane j at bits [2j+1:2j] |
| out_eoi_o | output | 3 | End-of-instruction marker per output lane |
| out_pop_i | input | 2 | Number of uops rename removes this cycle |

## Verification
In the same cycle, a decode group can be written at the tail while rename pops at the head, and a flush can arrive together with a valid group and a non-zero pop. The sweep covers every slot pattern, every uop count and every starting occupancy, with the pop count varying alongside them. A flush is also inserted into some of these same cycles. The bench keeps its own queue model built from the slot, fit and ordering rules, and compares the take count and every visible lane with that model on each cycle.

// File: rtl/usq_pkg.sv
package usq_pkg;
  localparam int unsigned SLOTS    = 3;
  localparam int unsigned MAX_UOPS = 4;
  localparam int unsigned Q_DEPTH  = 6;
  localparam int unsigned DRAIN    = 3;
  localparam int unsigned PAY_W    = 8;
  localparam int unsigned CNT_W    = 3;
  localparam int unsigned IDX_W    = $clog2(MAX_UOPS);
  localparam int unsigned OCC_W    = $clog2(Q_DEPTH + 1);
  localparam int unsigned LANE_W   = $clog2(Q_DEPTH);
  localparam int unsigned TAKE_W   = $clog2(SLOTS + 1);
  localparam int unsigned POP_W    = $clog2(DRAIN + 1);

  typedef struct packed {
    logic [PAY_W-1:0] pay;
    logic [IDX_W-1:0] idx;
    logic             eoi;
  } uop_t;
endpackage

// File: rtl/usq_steer.sv
module usq_steer
  import usq_pkg::*;
(
  input  logic                     flush_i,
  input  logic [SLOTS-1:0]         vld_i,
  input  logic [SLOTS*CNT_W-1:0]   ucnt_i,
  input  logic [SLOTS*PAY_W-1:0]   pay_i,
  input  logic [OCC_W-1:0]         free_i,
  output logic [TAKE_W-1:0]        take_o,
  output logic [OCC_W-1:0]         wr_n_o,
  output uop_t                     lane_o [Q_DEPTH]
);

  always_comb begin
    int   used;
    int   need;
    logic go;
    logic [LANE_W-1:0] li;
    take_o = '0;
    wr_n_o = '0;
    for (int k = 0; k < Q_DEPTH; k++) lane_o[k] = '0;
    used = 0;
    go   = !flush_i;
    li   = '0;
    for (int s = 0; s < SLOTS; s++) begin
      need = int'(ucnt_i[s*CNT_W +: CNT_W]);
      // slot 0 is the wide decoder, the rest are single-uop only
      if (go && vld_i[s] && need >= 1 &&
          need <= ((s == 0) ? int'(MAX_UOPS) : 1) &&
          used + need <= int'(free_i)) begin
        for (int u = 0; u < MAX_UOPS; u++) begin
          if (u < need) begin
            li = LANE_W'(used + u);
            lane_o[li].pay = pay_i[s*PAY_W +: PAY_W];
            lane_o[li].idx = IDX_W'(u);
            lane_o[li].eoi = (u == need - 1);
          end
        end
        used   = used + need;
        take_o = TAKE_W'(s + 1);
      end else begin
        go = 1'b0;
      end
    end
    wr_n_o = OCC_W'(used);
  end

endmodule

// File: rtl/usq_fifo.sv
module usq_fifo
  import usq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [OCC_W-1:0]  wr_n_i,
  input  uop_t              lane_i [Q_DEPTH],
  input  logic [POP_W-1:0]  pop_i,
  output logic [OCC_W-1:0]  occ_o,
  output uop_t              head_o [DRAIN]
);

  uop_t              mem [Q_DEPTH];
  logic [LANE_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0]  occ;
  logic [POP_W-1:0]  pop_eff;

  function automatic logic [LANE_W-1:0] wrap(input logic [LANE_W-1:0] p, input int add);
    return LANE_W'((int'(p) + add) % int'(Q_DEPTH));
  endfunction

  always_comb begin
    if (int'(pop_i) > int'(occ)) pop_eff = POP_W'(occ);
    else                         pop_eff = pop_i;
  end

  for (genvar j = 0; j < DRAIN; j++) begin : g_head
    assign head_o[j] = mem[wrap(rd_ptr, j)];
  end

  assign occ_o = occ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      for (int k = 0; k < Q_DEPTH; k++) mem[k] <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      for (int k = 0; k < Q_DEPTH; k++) begin
        if (k < int'(wr_n_i)) mem[wrap(wr_ptr, k)] <= lane_i[k];
      end
      wr_ptr <= wrap(wr_ptr, int'(wr_n_i));
      rd_ptr <= wrap(rd_ptr, int'(pop_eff));
      occ    <= occ + wr_n_i - OCC_W'(pop_eff);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ) <= int'(Q_DEPTH));

  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> occ == '0);

  a_r7_pop_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && wr_n_i == '0 && int'(pop_i) >= int'(occ)) |=> occ == '0);

endmodule

// File: rtl/uop_steer_queue.sv
module uop_steer_queue
  import usq_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [SLOTS-1:0]         in_vld_i,
  input  logic [SLOTS*CNT_W-1:0]   in_ucnt_i,
  input  logic [SLOTS*PAY_W-1:0]   in_pay_i,
  output logic [TAKE_W-1:0]        in_take_o,
  output logic [DRAIN-1:0]         out_vld_o,
  output logic [DRAIN*PAY_W-1:0]   out_pay_o,
  output logic [DRAIN*IDX_W-1:0]   out_idx_o,
  output logic [DRAIN-1:0]         out_eoi_o,
  input  logic [POP_W-1:0]         out_pop_i
);

  logic [OCC_W-1:0] occ, free, wr_n;
  uop_t             lanes [Q_DEPTH];
  uop_t             head  [DRAIN];

  assign free = OCC_W'(Q_DEPTH) - occ;

  usq_steer u_steer (
    .flush_i (flush_i),
    .vld_i   (in_vld_i),
    .ucnt_i  (in_ucnt_i),
    .pay_i   (in_pay_i),
    .free_i  (free),
    .take_o  (in_take_o),
    .wr_n_o  (wr_n),
    .lane_o  (lanes)
  );

  usq_fifo u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .wr_n_i  (wr_n),
    .lane_i  (lanes),
    .pop_i   (out_pop_i),
    .occ_o   (occ),
    .head_o  (head)
  );

  for (genvar j = 0; j < DRAIN; j++) begin : g_out
    assign out_vld_o[j]                 = int'(occ) > j;
    assign out_pay_o[j*PAY_W +: PAY_W]  = head[j].pay;
    assign out_idx_o[j*IDX_W +: IDX_W]  = head[j].idx;
    assign out_eoi_o[j]                 = head[j].eoi;
  end

  a_r3_narrow_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(in_take_o) >= 2 |-> in_ucnt_i[CNT_W +: CNT_W] == CNT_W'(1));

  a_r5_group_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_take_o != '0 |-> int'(in_ucnt_i[0 +: CNT_W]) + int'(occ) <= int'(Q_DEPTH));

  a_r8_no_take_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> in_take_o == '0);

  a_r7_thermometer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({1'b0, out_vld_o} + 1'b1));

  a_r10_long_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ucnt_i[0 +: CNT_W] == '0 || int'(in_ucnt_i[0 +: CNT_W]) > int'(MAX_UOPS)) |-> in_take_o == '0);

endmodule

// File: tb/uop_steer_queue_test.sv
module uop_steer_queue_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        flush = 0;
  logic [2:0]  vld = 0;
  logic [8:0]  ucnt = 0;
  logic [23:0] pay = 0;
  logic [1:0]  pop = 0;
  logic [1:0]  take;
  logic [2:0]  ovld;
  logic [23:0] opay;
  logic [5:0]  oidx;
  logic [2:0]  oeoi;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int seed = 0;
  logic [10:0] mq [0:15];
  int mcnt = 0;

  always #2 clk = ~clk;

  uop_steer_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .in_vld_i(vld), .in_ucnt_i(ucnt), .in_pay_i(pay), .in_take_o(take),
    .out_vld_o(ovld), .out_pay_o(opay), .out_idx_o(oidx), .out_eoi_o(oeoi),
    .out_pop_i(pop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // lanes and valid thermometer against the model (R7, R9, R2 fields)
  task automatic chk_out();
    int ev;
    ev = (mcnt > 3) ? 3 : mcnt;
    chk("R7 R6 R8 out_vld", int'(ovld), (1 << ev) - 1);
    for (int j = 0; j < ev; j++)
      chk("R9 R2 lane", int'({opay[j*8 +: 8], oidx[j*2 +: 2], oeoi[j]}), int'(mq[j]));
  endtask

  task automatic step(input logic fl, input logic [2:0] v, input int c0, input int c1,
                      input int c2, input int p);
    int cs [3];
    logic [7:0] ps [3];
    logic [10:0] nw [0:7];
    int nn, used, et, free, pe;
    logic go;
    cs[0] = c0; cs[1] = c1; cs[2] = c2;
    for (int s = 0; s < 3; s++) ps[s] = 8'(seed + s);
    seed += 3;
    @(negedge clk);
    flush = fl; vld = v; pop = 2'(p);
    ucnt = {3'(c2), 3'(c1), 3'(c0)};
    pay = {ps[2], ps[1], ps[0]};
    #1;
    // expected take: R3 R4 R5 R10
    free = 6 - mcnt; used = 0; et = 0; nn = 0; go = !fl;
    for (int s = 0; s < 3; s++) begin
      if (go && v[s] && cs[s] >= 1 && ((s == 0) ? cs[s] <= 4 : cs[s] == 1) && used + cs[s] <= free) begin
        for (int u = 0; u < cs[s]; u++) begin
          nw[nn] = {ps[s], 2'(u), (u == cs[s] - 1) ? 1'b1 : 1'b0};
          nn++;
        end
        used += cs[s];
        et = s + 1;
      end else go = 0;
    end
    chk("R3 R4 R5 R10 take", int'(take), et);
    chk_out();
    @(posedge clk);
    if (fl) mcnt = 0;
    else begin
      pe = (p > mcnt) ? mcnt : p;
      for (int k = 0; k + pe < mcnt; k++) mq[k] = mq[k + pe];
      mcnt -= pe;
      for (int k = 0; k < nn; k++) begin mq[mcnt] = nw[k]; mcnt++; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rem, lcg;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset out_vld", int'(ovld), 0);
    chk("R1 reset take", int'(take), 0);
    rst_n = 1;
    for (int occ = 0; occ <= 6; occ++)
      for (int c0 = 0; c0 <= 5; c0++)
        for (int c1 = 1; c1 <= 2; c1++)
          for (int c2 = 1; c2 <= 2; c2++)
            for (int v = 0; v < 8; v++) begin
              step(1, 3'b000, 1, 1, 1, 0);
              chk("R8 flushed", int'(ovld), 0);
              rem = occ;
              while (rem > 0) begin
                step(0, 3'b001, (rem > 4) ? 4 : rem, 1, 1, 0);
                rem -= (rem > 4) ? 4 : rem;
              end
              // flush colliding with a group and a pop (R8)
              step((c0 == 2 && c1 == 2 && v == 7) ? 1'b1 : 1'b0, 3'(v), c0, c1, c2, (c0 + v + occ) % 4);
              step(0, 3'b000, 1, 1, 1, 3);
              step(0, 3'b000, 1, 1, 1, 3);
            end
    // streaming without flush exercises wrap order (R9)
    lcg = 7;
    for (int i = 0; i < 2000; i++) begin
      lcg = (lcg * 1103 + 12345) % 65536;
      step(0, 3'(lcg >> 3), 1 + (lcg >> 6) % 4, 1 + ((lcg >> 9) % 5 == 0 ? 1 : 0),
           1 + ((lcg >> 11) % 6 == 0 ? 1 : 0), (lcg >> 13) % 4);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule